// File: doc/BRIEF.md
# Karatsuba Extension-Field Multiplier

This block multiplies two elements of the extension field GF(2^4m). Each operand is a polynomial of degree at most 3 in x. Its four coefficients are m-bit elements of the subfield GF(2^m). The subfield uses a polynomial basis whose reduction polynomial is a parameter. The product is reduced modulo x^4 + x + 1, so the result is again four m-bit coefficients.

The block first forms nine pairs of coefficient sums. It feeds these pairs into nine digit-serial subfield multipliers, which all start on the same cycle. An XOR network then merges the nine partial products. This network folds the reduction by x^4 + x + 1 into the combination, so no separate reduction step follows. A caller places both operands on the inputs and pulses `start` for one cycle. The caller takes the four result coefficients when `done` pulses. Each subfield unit consumes D bits of its second operand per cycle, so the latency is ceil(m/D) + 1 cycles.

Top module: `gf4_karatsuba_mul`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done` is 0 and all four result coefficients are 0.
- R2: Coefficient index k of each operand and of the result is the coefficient of x^k. Bit i of a coefficient is the coefficient of y^i in the subfield. The result equals the product of the two operands, with subfield products reduced by y^M + POLY and the outer product reduced by x^4 + x + 1.
- R3: `done` is high for exactly one cycle. It is sampled high on the (ceil(M/D)+1)-th rising edge after the edge that accepts `start`. Here D is the digit width.
- R4: A `start` that is sampled while a multiplication is in progress is ignored. The running result, its value and its `done` timing are unchanged, and no extra `done` follows.
- R5: Between two `done` pulses, the result coefficients hold the last delivered value. After reset they hold 0.
- R6: A `start` sampled in the same cycle that `done` is high is accepted. A new multiplication begins without an idle cycle in between.
- R7: Multiplying by the unit element (coefficient 0 equal to 1, the rest 0) returns the other operand unchanged. A zero operand gives a zero result.
- R8: The outer reduction uses x^4 = x + 1. For example, x times x^3 yields coefficient 0 = 1, coefficient 1 = 1 and coefficients 2 and 3 = 0.
- R9: The subfield reduction uses y^M = POLY. With M=7 and POLY=7'h03, y^6 times y in coefficient 0 yields 7'h03 in coefficient 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication (accepted only when idle or in the done cycle) |
| a0 | input | M | First operand, coefficient of x^0 |
| a1 | input | M | First operand, coefficient of x^1 |
| a2 | input | M | First operand, coefficient of x^2 |
| a3 | input | M | First operand, coefficient of x^3 |
| b0 | input | M | Second operand, coefficient of x^0 |
| b1 | input | M | Second operand, coefficient of x^1 |
| b2 | input | M | Second operand, coefficient of x^2 |
| b3 | input | M | Second operand, coefficient of x^3 |
| done | output | 1 | One-cycle pulse when the result is valid |
| c0 | output | M | Result, coefficient of x^0 |
| c1 | output | M | Result, coefficient of x^1 |
| c2 | output | M | Result, coefficient of x^2 |
| c3 | output | M | Result, coefficient of x^3 |

## Verification
Two events can land in the same cycle: the delivery of one result and the acceptance of the next `start`. The bench waits for a `done` pulse and raises `start` with fresh operands on that same cycle. It then checks three things. The delivered coefficients match the earlier operands. The new result arrives exactly ceil(M/D)+1 edges later. The coefficients do not change in the cycles between the two pulses. A second contrast case raises `start` during the run itself, and the bench confirms that the request is dropped.

// File: rtl/gf4_kara_pkg.sv
package gf4_kara_pkg;

  // Control state of one subfield unit.
  typedef enum logic {
    UNIT_IDLE = 1'b0,
    UNIT_RUN  = 1'b1
  } unit_state_e;

  // Number of partial products of the four-term split.
  localparam int NUM_PARTIALS = 9;
  localparam int NUM_COEFFS   = 4;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/gfm_digit_mul.sv
module gfm_digit_mul #(
  parameter int          M    = 7,
  parameter int          D    = 2,
  parameter logic [M-1:0] POLY = 7'h03
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [M-1:0] p_o
);
  import gf4_kara_pkg::*;

  localparam int NDIG = ceil_div(M, D);
  localparam int PADW = NDIG * D;
  localparam int CW   = $clog2(NDIG + 1);

  logic [M-1:0]    a_q;
  logic [PADW-1:0] b_q;
  logic [M-1:0]    acc_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;
  unit_state_e     state;

  // Multiply by y and reduce by y^M + POLY.
  function automatic logic [M-1:0] times_y(input logic [M-1:0] v);
    logic [M-1:0] r;
    r = {v[M-2:0], 1'b0};
    if (v[M-1]) r = r ^ POLY;
    return r;
  endfunction

  // One digit step, most significant digit bit first: acc*y^D + a*digit.
  function automatic logic [M-1:0] digit_step(input logic [M-1:0] acc,
                                              input logic [M-1:0] a,
                                              input logic [D-1:0] dig);
    logic [M-1:0] r;
    r = acc;
    for (int j = D - 1; j >= 0; j--) begin
      r = times_y(r);
      if (dig[j]) r = r ^ a;
    end
    return r;
  endfunction

  assign state  = (cnt_q != '0) ? UNIT_RUN : UNIT_IDLE;
  assign busy_o = (state == UNIT_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i && state == UNIT_IDLE) begin
        a_q   <= a_i;
        b_q   <= PADW'(b_i);
        acc_q <= '0;
        cnt_q <= CW'(NDIG);
      end else if (state == UNIT_RUN) begin
        acc_q <= digit_step(acc_q, a_q, b_q[PADW-1 -: D]);
        b_q   <= b_q << D;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign p_o    = acc_q;

  // R4: a running unit keeps counting down even if go_i is raised again.
  p_count_steps_r4: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R3: completion is flagged only after the final digit step.
  p_done_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(cnt_q) == CW'(1)));

  // R3: a completing unit is idle in the completion cycle.
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

endmodule

// File: rtl/kara_operand_sums.sv
module kara_operand_sums #(
  parameter int M = 7
) (
  input  logic [3:0][M-1:0] a_i,
  input  logic [3:0][M-1:0] b_i,
  output logic [8:0][M-1:0] opa_o,
  output logic [8:0][M-1:0] opb_o
);

  // Forms the nine operand pairs of the four-term Karatsuba split.
  function automatic logic [8:0][M-1:0] pair_terms(input logic [3:0][M-1:0] v);
    logic [8:0][M-1:0] t;
    logic [M-1:0]      lo, hi;
    lo   = v[0] ^ v[1];
    hi   = v[2] ^ v[3];
    t[0] = v[0];
    t[1] = v[1];
    t[2] = v[2];
    t[3] = v[3];
    t[4] = lo;
    t[5] = v[0] ^ v[2];
    t[6] = v[1] ^ v[3];
    t[7] = hi;
    t[8] = lo ^ hi;
    return t;
  endfunction

  assign opa_o = pair_terms(a_i);
  assign opb_o = pair_terms(b_i);

endmodule

// File: rtl/kara_combine.sv
module kara_combine #(
  parameter int M = 7
) (
  input  logic [8:0][M-1:0] q_i,
  output logic [3:0][M-1:0] c_o
);

  // Merges the partial products and folds x^4 = x + 1 in one network.
  function automatic logic [3:0][M-1:0] fold_partials(input logic [8:0][M-1:0] q);
    logic [3:0][M-1:0] c;
    logic [M-1:0]      s01, s012, s67, s57;
    s01  = q[0] ^ q[1];
    s012 = s01 ^ q[2];
    s67  = q[6] ^ q[7];
    s57  = q[5] ^ q[7];
    c[0] = s012 ^ q[3] ^ q[6];
    c[1] = q[0] ^ q[4] ^ s67;
    c[2] = s01 ^ s57;
    c[3] = s012 ^ q[4] ^ s57 ^ q[6] ^ q[8];
    return c;
  endfunction

  assign c_o = fold_partials(q_i);

endmodule

// File: rtl/gf4_karatsuba_mul.sv
module gf4_karatsuba_mul #(
  parameter int           M    = 7,
  parameter int           D    = 2,
  parameter logic [M-1:0] POLY = 7'h03
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a0,
  input  logic [M-1:0] a1,
  input  logic [M-1:0] a2,
  input  logic [M-1:0] a3,
  input  logic [M-1:0] b0,
  input  logic [M-1:0] b1,
  input  logic [M-1:0] b2,
  input  logic [M-1:0] b3,
  output logic         done,
  output logic [M-1:0] c0,
  output logic [M-1:0] c1,
  output logic [M-1:0] c2,
  output logic [M-1:0] c3
);
  import gf4_kara_pkg::*;

  localparam int NDIG = ceil_div(M, D);
  localparam int LAT  = NDIG + 1;
  localparam int LW   = $clog2(LAT + 2);

  logic [3:0][M-1:0]              a_vec, b_vec;
  logic [NUM_PARTIALS-1:0][M-1:0] opa, opb, part;
  logic [NUM_PARTIALS-1:0]        sub_done, sub_busy;
  logic [3:0][M-1:0]              comb_c;
  logic [3:0][M-1:0]              c_q;
  logic                           busy_q, done_q;
  logic                           go, all_done;

  assign a_vec = {a3, a2, a1, a0};
  assign b_vec = {b3, b2, b1, b0};

  assign go       = start && !busy_q;
  assign all_done = &sub_done;

  kara_operand_sums #(.M(M)) u_sums (
    .a_i  (a_vec),
    .b_i  (b_vec),
    .opa_o(opa),
    .opb_o(opb)
  );

  for (genvar g = 0; g < NUM_PARTIALS; g++) begin : g_unit
    gfm_digit_mul #(.M(M), .D(D), .POLY(POLY)) u_mul (
      .clk   (clk),
      .rst   (rst),
      .go_i  (go),
      .a_i   (opa[g]),
      .b_i   (opb[g]),
      .busy_o(sub_busy[g]),
      .done_o(sub_done[g]),
      .p_o   (part[g])
    );
  end

  kara_combine #(.M(M)) u_comb (
    .q_i(part),
    .c_o(comb_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      c_q    <= '0;
    end else begin
      done_q <= all_done;
      if (all_done) begin
        c_q    <= comb_c;
        busy_q <= 1'b0;
      end else if (go) begin
        busy_q <= 1'b1;
      end
    end
  end

  assign done = done_q;
  assign c0   = c_q[0];
  assign c1   = c_q[1];
  assign c2   = c_q[2];
  assign c3   = c_q[3];

  // Checker counter: edges since the accepting edge.
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (go)     lat_q <= LW'(1);
    else if (busy_q) lat_q <= lat_q + LW'(1);
  end

  // R2: the nine units finish together.
  p_lockstep_r2: assert property (@(posedge clk) disable iff (rst)
    (|sub_done) |-> (&sub_done));

  // R3: the units finish NDIG edges after acceptance, so done lands one later.
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    all_done |-> (lat_q == LW'(LAT)));

  // R3: done is a single-cycle pulse.
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: a start during a run leaves the run in place.
  p_start_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (start && busy_q && !all_done) |=> (busy_q && $stable(lat_q) == 1'b0));

  // R5: results change only with a done pulse.
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(c_q));

  // R6: acceptance finds every unit idle, and a start in the done cycle begins a run.
  p_units_idle_r6: assert property (@(posedge clk) disable iff (rst)
    go |-> (sub_busy == '0));
  p_back_to_back_r6: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> busy_q);

endmodule

// File: tb/gf4_karatsuba_mul_test.sv
`timescale 1ns/1ps
module gf4_karatsuba_mul_test;
  localparam int           M    = 7;
  localparam int           D    = 2;
  localparam logic [M-1:0] POLY = 7'h03;
  localparam int           NDIG = (M + D - 1) / D;

  typedef logic [3:0][M-1:0] elem_t;
  typedef struct {
    elem_t c;
    int    due;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  elem_t        a = '0, b = '0;
  logic         done;
  logic [M-1:0] c0, c1, c2, c3;
  elem_t        c_obs;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  exp_t  sb[$];
  elem_t last_c = '0;
  bit    mon_on = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gf4_karatsuba_mul #(.M(M), .D(D), .POLY(POLY)) uut (
    .clk(clk), .rst(rst), .start(start),
    .a0(a[0]), .a1(a[1]), .a2(a[2]), .a3(a[3]),
    .b0(b[0]), .b1(b[1]), .b2(b[2]), .b3(b[3]),
    .done(done), .c0(c0), .c1(c1), .c2(c2), .c3(c3)
  );
  assign c_obs = {c3, c2, c1, c0};

  // Schoolbook subfield product, then reduction from the top bit down.
  function automatic logic [M-1:0] ref_smul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [2*M-1:0] p;
    logic [2*M-1:0] f;
    p = '0;
    for (int i = 0; i < M; i++) if (y[i]) p = p ^ ((2*M)'(x) << i);
    f = (2*M)'(POLY) | ((2*M)'(1) << M);
    for (int k = 2*M - 2; k >= M; k--) if (p[k]) p = p ^ (f << (k - M));
    return p[M-1:0];
  endfunction

  function automatic elem_t ref_emul(input elem_t x, input elem_t y);
    logic [M-1:0] g[7];
    elem_t r;
    for (int k = 0; k < 7; k++) g[k] = '0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) g[i+j] = g[i+j] ^ ref_smul(x[i], y[j]);
    for (int k = 6; k >= 4; k--) begin
      g[k-4] = g[k-4] ^ g[k];
      g[k-3] = g[k-3] ^ g[k];
    end
    for (int k = 0; k < 4; k++) r[k] = g[k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Driver: called at a falling edge; start is sampled on the next rising edge.
  task automatic issue(input elem_t x, input elem_t y, input string tag);
    exp_t e;
    a = x; b = y; start = 1'b1;
    e.c = ref_emul(x, y);
    e.due = cyc + NDIG + 2;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_one(input elem_t x, input elem_t y, input string tag);
    issue(x, y, tag);
    wait_done();
    @(negedge clk);
  endtask

  // Monitor: scoreboard comparison away from the active edge.
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R4", "unexpected done", 64'(1), 64'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(c_obs == e.c, e.tag, "result", 64'(c_obs), 64'(e.c));
          chk(cyc == e.due, "R3", "done cycle", 64'(cyc), 64'(e.due));
        end
        last_c = c_obs;
      end else begin
        chk(c_obs == last_c, "R5", "hold between results", 64'(c_obs), 64'(last_c));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    elem_t x, y, z, one, xe, x3;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'(0));
    chk(c_obs == '0, "R1", "result in reset", 64'(c_obs), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'(0));
    chk(c_obs == '0, "R1", "result after reset", 64'(c_obs), 64'(0));
    mon_on = 1'b1;

    // R7: unit and zero operands
    one = '0; one[0] = 7'h01;
    y = {7'h55, 7'h2A, 7'h13, 7'h7F};
    run_one(one, y, "R7");
    run_one(y, one, "R7");
    run_one('0, y, "R7");

    // R8: x * x^3 = x + 1
    xe = '0; xe[1] = 7'h01;
    x3 = '0; x3[3] = 7'h01;
    run_one(xe, x3, "R8");
    // R9: y^6 * y = y + 1 in the subfield
    x = '0; x[0] = 7'h40;
    z = '0; z[0] = 7'h02;
    run_one(x, z, "R9");

    // R2: all-ones and assorted operands
    run_one({4{7'h7F}}, {4{7'h7F}}, "R2");
    for (int n = 0; n < 12; n++) begin
      for (int i = 0; i < 4; i++) begin
        x[i] = M'($urandom);
        y[i] = M'($urandom);
      end
      run_one(x, y, "R2");
    end

    // R4: start raised twice during a run with other operands
    x = {7'h11, 7'h22, 7'h33, 7'h44};
    y = {7'h5A, 7'h06, 7'h70, 7'h01};
    issue(x, y, "R4");
    a = {4{7'h7F}}; b = {4{7'h3C}}; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    @(negedge clk);
    repeat (NDIG + 3) @(negedge clk);
    chk(sb.size() == 0, "R4", "pending after ignored start", 64'(sb.size()), 64'(0));

    // R6: new start in the done cycle, chained three times
    x = {7'h01, 7'h02, 7'h04, 7'h08};
    issue(x, y, "R6");
    wait_done();
    issue(y, x, "R6");
    wait_done();
    issue(x, x, "R6");
    wait_done();
    @(negedge clk);
    repeat (NDIG + 3) @(negedge clk);
    chk(sb.size() == 0, "R6", "all chained results seen", 64'(sb.size()), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule